// File: doc/BRIEF.md
# Multi-channel mailbox send inbox

This block is the transmit half of an inter-processor mailbox with eight channels. A local processor uses a plain word-addressed register port. To send, it writes the lower and upper 32-bit halves of a 64-bit message and the number of the target channel, then writes a trigger. The block copies the message into that channel's pending slot and marks the channel busy. The remote core sees the busy vector. It picks a channel, reads the slot contents and pulses a fetch strobe. That fetch frees the slot and records a delivery for the channel.

Each channel has three status flags: busy, delivered and overflow. All three are packed into one status word, in three 8-bit lanes. The processor clears the delivered and overflow flags by writing ones to a clear register. A single level interrupt reports delivered and overflow events. Each event type can be masked on its own. The interrupt stays pending until the processor clears it through a separate interrupt-status register.

Top module: `ipc_send_inbox`

## Requirements
- R1: After reset, the status word (0x14) and interrupt status (0x18) read 0, the mask register (0x1C) reads 3'b111, `irq` is low and `pendMask` is 0.
- R2: A write to 0x0C with data bit 0 = 1 is a trigger. If the target channel is idle, the trigger copies the current low word (0x04) and high word (0x08) into the slot of the channel held in the ID register (0x00). It also sets that channel's busy bit, which is status bit [ch] and `pendMask[ch]`. A write to 0x0C with bit 0 = 0 does nothing.
- R3: `fetchData` shows {high, low} of the slot selected by `fetchCh`. A `fetchEn` pulse on a busy channel clears its busy bit and sets its delivered bit (status bit [16+ch]) at the next edge. A `fetchEn` pulse on an idle channel has no effect.
- R4: A trigger aimed at a channel that is already busy leaves that channel's slot unchanged and sets its overflow bit (status bit [8+ch]).
- R5: A write to 0x10 clears every delivered and overflow bit whose position is 1 in the written value. Busy bits are unaffected. A flag that is set and cleared at the same edge ends up set.
- R6: Interrupt-status bit 0 (0x18) is set by a delivered event while mask bit 2 is 0, or by an overflow event while mask bit 1 is 0. The bit stays set until cleared, and `irq` follows it.
- R7: Writing 0x18 with bit 0 = 1 clears the pending interrupt. Writing it with bit 0 = 0 leaves the interrupt unchanged.
- R8: Mask register 0x1C holds bits [2:0], where a 1 masks a source. Bit 0, the blocked source, has no event behind it and never raises `irq`.
- R9: The ID, low-word and high-word registers read back the last value written to them. The ID register reads back only its low 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| fetchEn | input | 1 | Remote side takes the slot of `fetchCh` |
| fetchCh | input | 3 | Channel selected by the remote side |
| fetchData | output | 64 | Slot contents of `fetchCh`, high word in the upper half |
| pendMask | output | 8 | Per-channel busy flags |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default of eight channels and a 6-bit address. At that size, every channel can be filled, overflowed and drained in one sweep. Every one of the eight mask values is also tried against both an overflow event and a delivered event. The expected status word and interrupt level come from a small flag model in the bench. That model is updated from the requirements after each send, fetch and clear.

// File: rtl/ipc_inbox_pkg.sv
package ipc_inbox_pkg;
  localparam logic [3:0] IdxId    = 4'd0;
  localparam logic [3:0] IdxLo    = 4'd1;
  localparam logic [3:0] IdxHi    = 4'd2;
  localparam logic [3:0] IdxTrig  = 4'd3;
  localparam logic [3:0] IdxClr   = 4'd4;
  localparam logic [3:0] IdxStat  = 4'd5;
  localparam logic [3:0] IdxIrq   = 4'd6;
  localparam logic [3:0] IdxMask  = 4'd7;

  typedef struct packed {
    logic wrId;
    logic wrLo;
    logic wrHi;
    logic trig;
    logic clrFlags;
    logic clrIrq;
    logic wrMask;
  } inboxStrobes_t;
endpackage

// File: rtl/ipc_inbox_ctrl.sv
module ipc_inbox_ctrl
  import ipc_inbox_pkg::*;
#(
  parameter int AddrW = 6
) (
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic             wrBit0,
  output inboxStrobes_t    strb
);
  logic [3:0] wordIdx;
  assign wordIdx = 4'(addr[AddrW-1:2]);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (wordIdx)
        IdxId:   strb.wrId     = 1'b1;
        IdxLo:   strb.wrLo     = 1'b1;
        IdxHi:   strb.wrHi     = 1'b1;
        IdxTrig: strb.trig     = wrBit0;
        IdxClr:  strb.clrFlags = 1'b1;
        IdxIrq:  strb.clrIrq   = wrBit0;
        IdxMask: strb.wrMask   = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipc_inbox_dp.sv
module ipc_inbox_dp
  import ipc_inbox_pkg::*;
#(
  parameter int NCh   = 8,
  parameter int AddrW = 6,
  localparam int IdW  = (NCh > 1) ? $clog2(NCh) : 1,
  localparam int Lane = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  inboxStrobes_t    strb,
  input  logic [31:0]      wrData,
  input  logic [AddrW-1:0] addr,
  input  logic             fetchEn,
  input  logic [IdW-1:0]   fetchCh,
  output logic [31:0]      rdData,
  output logic [63:0]      fetchData,
  output logic [NCh-1:0]   busyV,
  output logic [NCh-1:0]   dlvV,
  output logic [NCh-1:0]   ovfV,
  output logic [IdW-1:0]   curId,
  output logic             irqPend
);
  logic [31:0]    loReg, hiReg;
  logic [31:0]    slotLo [NCh];
  logic [31:0]    slotHi [NCh];
  logic [2:0]     maskReg;
  logic [NCh-1:0] dlvSet, ovfSet, acceptV, fetchV;
  logic           fetchOk, irqEv;

  assign fetchOk = fetchEn && (int'(fetchCh) < NCh) && busyV[fetchCh];

  for (genvar c = 0; c < NCh; c++) begin : g_ch
    logic sel;
    assign sel        = strb.trig && (int'(curId) == c);
    assign acceptV[c] = sel && !busyV[c];
    assign ovfSet[c]  = sel && busyV[c];
    assign fetchV[c]  = fetchOk && (int'(fetchCh) == c);
    assign dlvSet[c]  = fetchV[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotLo[c] <= '0;
        slotHi[c] <= '0;
        busyV[c]  <= 1'b0;
        dlvV[c]   <= 1'b0;
        ovfV[c]   <= 1'b0;
      end else begin
        if (acceptV[c]) begin
          slotLo[c] <= loReg;
          slotHi[c] <= hiReg;
        end
        busyV[c] <= acceptV[c] | (busyV[c] & ~fetchV[c]);
        dlvV[c]  <= dlvSet[c] | (dlvV[c] & ~(strb.clrFlags & wrData[2*Lane+c]));
        ovfV[c]  <= ovfSet[c] | (ovfV[c] & ~(strb.clrFlags & wrData[Lane+c]));
      end
    end
  end

  assign irqEv = ((|dlvSet) && !maskReg[2]) || ((|ovfSet) && !maskReg[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loReg   <= '0;
      hiReg   <= '0;
      curId   <= '0;
      maskReg <= 3'b111;
      irqPend <= 1'b0;
    end else begin
      if (strb.wrLo)   loReg   <= wrData;
      if (strb.wrHi)   hiReg   <= wrData;
      if (strb.wrId)   curId   <= wrData[IdW-1:0];
      if (strb.wrMask) maskReg <= wrData[2:0];
      irqPend <= irqEv | (irqPend & ~strb.clrIrq);
    end
  end

  always_comb begin
    fetchData = '0;
    if (int'(fetchCh) < NCh) fetchData = {slotHi[fetchCh], slotLo[fetchCh]};
  end

  always_comb begin
    rdData = '0;
    unique case (4'(addr[AddrW-1:2]))
      IdxId:   rdData[IdW-1:0] = curId;
      IdxLo:   rdData = loReg;
      IdxHi:   rdData = hiReg;
      IdxStat: begin
        rdData[NCh-1:0]          = busyV;
        rdData[Lane+NCh-1:Lane]  = ovfV;
        rdData[2*Lane+NCh-1:2*Lane] = dlvV;
      end
      IdxIrq:  rdData[0]   = irqPend;
      IdxMask: rdData[2:0] = maskReg;
      default: ;
    endcase
  end
endmodule

// File: rtl/ipc_send_inbox.sv
module ipc_send_inbox
  import ipc_inbox_pkg::*;
#(
  parameter int NCh   = 8,
  parameter int AddrW = 6,
  localparam int IdW  = (NCh > 1) ? $clog2(NCh) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic             fetchEn,
  input  logic [IdW-1:0]   fetchCh,
  output logic [63:0]      fetchData,
  output logic [NCh-1:0]   pendMask,
  output logic             irq
);
  inboxStrobes_t  strb;
  logic [NCh-1:0] dlvV, ovfV;
  logic [IdW-1:0] curId;

  ipc_inbox_ctrl #(.AddrW(AddrW)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrBit0(wrData[0]), .strb(strb)
  );

  ipc_inbox_dp #(.NCh(NCh), .AddrW(AddrW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .addr(addr),
    .fetchEn(fetchEn), .fetchCh(fetchCh), .rdData(rdData),
    .fetchData(fetchData), .busyV(pendMask), .dlvV(dlvV), .ovfV(ovfV),
    .curId(curId), .irqPend(irq)
  );
endmodule

// File: rtl/ipc_send_inbox_chk.sv
module ipc_send_inbox_chk #(
  parameter int NCh   = 8,
  parameter int AddrW = 6,
  localparam int IdW  = (NCh > 1) ? $clog2(NCh) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [AddrW-1:0] addr,
  input logic [31:0]      wrData,
  input logic             fetchEn,
  input logic [IdW-1:0]   fetchCh,
  input logic [NCh-1:0]   pendMask,
  input logic [NCh-1:0]   dlvV,
  input logic [NCh-1:0]   ovfV,
  input logic [IdW-1:0]   curId,
  input logic             irq
);
  logic trigW, irqClrW;
  assign trigW   = wrEn && (addr[AddrW-1:2] == 3) && wrData[0];
  assign irqClrW = wrEn && (addr[AddrW-1:2] == 6) && wrData[0];

  // R2
  send_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigW && !pendMask[curId] |=> pendMask[$past(curId)]);

  // R4
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigW && pendMask[curId] |=> ovfV[$past(curId)] && pendMask[$past(curId)]);

  // R3
  fetch_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn && pendMask[fetchCh] |=> !pendMask[$past(fetchCh)] && dlvV[$past(fetchCh)]);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqClrW |=> irq);

  // R7
  irq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(irqClrW));
endmodule

bind ipc_send_inbox ipc_send_inbox_chk #(.NCh(NCh), .AddrW(AddrW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .fetchEn(fetchEn), .fetchCh(fetchCh), .pendMask(pendMask),
  .dlvV(dlvV), .ovfV(ovfV), .curId(curId), .irq(irq)
);

// File: tb/sim_ipc_send_inbox.sv
`timescale 1ns/1ps
module sim_ipc_send_inbox;
  logic clk = 0, rstN = 0, wrEn = 0, fetchEn = 0, irq;
  logic [5:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [2:0] fetchCh = '0;
  logic [63:0] fetchData;
  logic [7:0] pendMask;
  int checks = 0, errors = 0;

  logic [7:0] eBusy = 0, eDlv = 0, eOvf = 0;
  logic [2:0] eMask = 3'b111;
  logic eIrq = 0;
  logic [31:0] eLo [8];
  logic [31:0] eHi [8];

  always #4 clk = ~clk;

  ipc_send_inbox u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .fetchEn(fetchEn), .fetchCh(fetchCh),
    .fetchData(fetchData), .pendMask(pendMask), .irq(irq));

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic send(int ch, logic [31:0] lo, logic [31:0] hi);
    wr(6'h04, lo); wr(6'h08, hi); wr(6'h00, 32'(ch)); wr(6'h0C, 32'h1);
    if (eBusy[ch]) begin
      eOvf[ch] = 1;
      if (!eMask[1]) eIrq = 1;
    end else begin
      eBusy[ch] = 1; eLo[ch] = lo; eHi[ch] = hi;
    end
  endtask

  task automatic fetch(int ch);
    @(negedge clk); fetchEn = 1; fetchCh = 3'(ch);
    @(negedge clk); fetchEn = 0;
    if (eBusy[ch]) begin
      eBusy[ch] = 0; eDlv[ch] = 1;
      if (!eMask[2]) eIrq = 1;
    end
  endtask

  task automatic checkState(string req);
    logic [31:0] v;
    rd(6'h14, v);
    chk(req, v, {8'h0, eDlv, eOvf, eBusy});
    chk(req, pendMask, eBusy);
    chk(req, irq, eIrq);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h14, v); chk("R1", v, 0);
    rd(6'h18, v); chk("R1", v, 0);
    rd(6'h1C, v); chk("R1", v, 7);
    chk("R1", irq, 0); chk("R1", pendMask, 0);

    // R9 readback
    wr(6'h00, 32'hFFFF_FFFD); rd(6'h00, v); chk("R9", v, 5);
    wr(6'h04, 32'h1234_5678); rd(6'h04, v); chk("R9", v, 32'h1234_5678);
    wr(6'h08, 32'h9ABC_DEF0); rd(6'h08, v); chk("R9", v, 32'h9ABC_DEF0);

    // R2 trigger with bit 0 = 0 is ignored
    wr(6'h0C, 32'hFFFF_FFFE); checkState("R2");

    // R2 send on every channel
    for (int c = 0; c < 8; c++) begin
      send(c, 32'hA500_0000 ^ (32'(c) * 32'h0101_0101), 32'h5A00_0000 + 32'(c * 7));
      checkState("R2");
    end
    // R3 slot contents visible per channel
    for (int c = 0; c < 8; c++) begin
      fetchCh = 3'(c); #1; chk("R3", fetchData, {eHi[c], eLo[c]});
    end

    // R4 overflow on even channels keeps old slot; masked, no irq (R8)
    for (int c = 0; c < 8; c += 2) begin
      send(c, 32'hDEAD_0000 + 32'(c), 32'hBEEF_0000);
      checkState("R4");
    end
    for (int c = 0; c < 8; c += 2) begin
      fetchCh = 3'(c); #1; chk("R4", fetchData, {eHi[c], eLo[c]});
    end

    // R3 fetch, then fetch of idle channel ignored
    fetch(3); checkState("R3");
    fetch(3); checkState("R3");

    // R5 selective clear; busy bits in the value have no effect
    wr(6'h10, 32'h0008_05FF);
    eDlv &= ~8'h08; eOvf &= ~8'h05;
    checkState("R5");

    // R6/R7 delivered unmasked
    wr(6'h1C, 32'h3); eMask = 3'b011;
    fetch(0); checkState("R6");
    repeat (3) @(negedge clk);
    chk("R6", irq, 1);
    rd(6'h18, v); chk("R6", v, 1);
    wr(6'h18, 32'h0); chk("R7", irq, 1);
    wr(6'h18, 32'h1); eIrq = 0; chk("R7", irq, 0);
    rd(6'h18, v); chk("R7", v, 0);

    // R8 all mask values against overflow and delivered events
    for (int m = 0; m < 8; m++) begin
      wr(6'h1C, 32'(m)); eMask = 3'(m);
      rd(6'h1C, v); chk("R8", v, 32'(m));
      wr(6'h10, 32'h00FF_FF00); eDlv = 0; eOvf = 0;
      if (!eBusy[5]) send(5, 32'(m), 32'(m + 1));
      send(5, 32'hFFFF_0000, 32'(m));
      checkState("R8");
      wr(6'h18, 32'h1); eIrq = 0;
      fetch(5);
      checkState("R8");
      wr(6'h18, 32'h1); eIrq = 0;
      chk("R7", irq, 0);
    end

    // R5 set wins over clear at the same edge
    send(6, 32'h1, 32'h2);
    @(negedge clk); fetchEn = 1; fetchCh = 3'd6;
    wrEn = 1; addr = 6'h10; wrData = 32'h0040_0000;
    @(negedge clk); fetchEn = 0; wrEn = 0;
    eBusy[6] = 0; eDlv[6] = 1;
    if (!eMask[2]) eIrq = 1;
    checkState("R5");

    // R3 drain the rest
    for (int c = 0; c < 8; c++) begin
      fetch(c); checkState("R3");
    end
    chk("R3", pendMask, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule